// File: doc/BRIEF.md
# APB4 Address-Decoding Fanout Splitter

This block sits between one upstream APB4 requester and a set of downstream APB4 completers. It presents a single completer port upstream and several requester ports downstream. A fixed address map, set by parameters, assigns each upstream transfer to exactly one downstream port. That port sees the upstream address, write data, byte strobes, protection bits and direction unchanged. Its ready, error and read data are steered back to the upstream side.

The address map holds a list of regions. A region is a single target or an array of identical targets in one or two dimensions. Each array element owns its own complete downstream port. An element is picked by shifting the offset from the region base right by the power-of-two stride. Two-dimensional arrays are laid out row-major. Downstream ports are numbered region by region, and inside a region by element index.

The path from input to output has no registers. The clock and reset inputs exist only so that the embedded protocol checks have something to sample on. A transfer to an address that no region claims selects no downstream port. The block then completes that transfer itself with an error.

Top module: `apb_fanout_split`

## Requirements
- R1: While upstream select is high and the address falls in a mapped element, exactly that element's downstream select is 1. Every other downstream select is 0, including the other elements of the same array.
- R2: While upstream select is 0, every downstream select and every downstream enable is 0, whatever the address.
- R3: Every downstream port carries the upstream address, write data, strobe (including an all-ones mask), 3-bit protection and write direction bit for bit.
- R4: The selected port's enable equals the upstream enable, so it sees the same setup phase (enable 0) and access phase (enable 1). Ports that are not selected have enable 0.
- R5: Upstream read data, ready and error equal the selected port's read data, ready and error. A selected port holding ready low stalls the upstream side.
- R6: Element index = (address − region base) >> stride_log2. For a region of rows×cols elements, element [r][c] has index r·cols + c. Its downstream port number is the sum of the element counts of all earlier regions, plus the index. Default map: region 0 is a single target at 0x0000 with stride 0x100 (port 0). Region 1 is a 1×4 array at 0x1000 with stride 0x100 (ports 1–4). Region 2 is a 2×3 array at 0x2000 with stride 0x40 (ports 5–10).
- R7: If upstream select is high and the address hits no region, no downstream select is asserted. Upstream ready is then 1, error is 1 and read data is 0.
- R8: While upstream select is 0, upstream read data, ready and error are all 0, even if downstream ports drive nonzero values.
- R9: Every output follows its inputs in the same cycle, with no clock edge in between.
- R10: The last byte of a region maps to the region's last element. The first byte past the region end is unmapped (for example 0x00FF → port 0, 0x0100 unmapped; 0x217F → port 10, 0x2180 unmapped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled only by embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables checks |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable (access phase) |
| s_pwrite | input | 1 | Upstream direction, 1 = write |
| s_paddr | input | AW (16) | Upstream address |
| s_pprot | input | 3 | Upstream protection attributes |
| s_pwdata | input | DW (32) | Upstream write data |
| s_pstrb | input | DW/8 (4) | Upstream byte strobes |
| s_prdata | output | DW (32) | Read data returned upstream |
| s_pready | output | 1 | Ready returned upstream |
| s_pslverr | output | 1 | Error returned upstream |
| m_psel | output | NPORT (11) | Per-port downstream select |
| m_penable | output | NPORT (11) | Per-port downstream enable |
| m_pwrite | output | NPORT (11) | Per-port direction |
| m_paddr | output | NPORT·AW (176) | Per-port address, port p in bits [p·AW +: AW] |
| m_pprot | output | NPORT·3 (33) | Per-port protection |
| m_pwdata | output | NPORT·DW (352) | Per-port write data |
| m_pstrb | output | NPORT·DW/8 (44) | Per-port strobes |
| m_prdata | input | NPORT·DW (352) | Per-port read data |
| m_pready | input | NPORT (11) | Per-port ready |
| m_pslverr | input | NPORT (11) | Per-port error |

## Verification
Every downstream port is given a different read-data word and an alternating error bit. A correct mux therefore cannot return the right response for the wrong port, and a decode that is off by one element shows up at once. The sweep uses one address in each element of every region with a changing protection value and write pattern, in both setup and access phases. This separates a wrong array index, including a swapped row and column in the two-dimensional region, from wrong field forwarding. Addresses at the last byte and one past the end of regions show whether the range compare is off by one. A single stalled port tells real ready steering apart from a constant ready. Idle-select and unmapped transfers separate the quiet zero response from the self-generated error response.

// File: rtl/apb_split_pkg.sv
package apb_split_pkg;

  // One address region: a base, a power-of-two element stride and a
  // rows x cols element array (1x1 for a single target).
  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  stride_log2;
    logic [15:0] rows;
    logic [15:0] cols;
  } region_cfg_t;

  function automatic int unsigned region_count(input region_cfg_t c);
    return int'(c.rows) * int'(c.cols);
  endfunction

endpackage

// File: rtl/apb_region_decode.sv
module apb_region_decode #(
  parameter int unsigned AW = 16,
  parameter apb_split_pkg::region_cfg_t CFG = '{base: 32'h0, stride_log2: 8'd8,
                                                rows: 16'd1, cols: 16'd1},
  localparam int unsigned CNT = apb_split_pkg::region_count(CFG)
) (
  input  logic           up_psel,
  input  logic [AW-1:0]  paddr,
  output logic [CNT-1:0] elem_sel
);

  localparam logic [AW-1:0] BASE = AW'(CFG.base);

  logic          above_base;
  logic [AW-1:0] offs;
  logic [AW-1:0] idx;

  assign above_base = (paddr >= BASE);
  assign offs       = paddr - BASE;
  assign idx        = offs >> CFG.stride_log2;

  // One comparator per element; indexes at or past CNT match nothing.
  for (genvar e = 0; e < CNT; e++) begin : g_elem
    assign elem_sel[e] = up_psel && above_base && (idx == AW'(e));
  end

endmodule

// File: rtl/apb_req_fanout.sv
module apb_req_fanout #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned NPORT = 11,
  localparam int unsigned SW   = DW / 8
) (
  input  logic              up_penable,
  input  logic              up_pwrite,
  input  logic [AW-1:0]     up_paddr,
  input  logic [2:0]        up_pprot,
  input  logic [DW-1:0]     up_pwdata,
  input  logic [SW-1:0]     up_pstrb,
  input  logic [NPORT-1:0]  port_sel,
  output logic [NPORT-1:0]  m_psel,
  output logic [NPORT-1:0]  m_penable,
  output logic [NPORT-1:0]  m_pwrite,
  output logic [NPORT*AW-1:0] m_paddr,
  output logic [NPORT*3-1:0]  m_pprot,
  output logic [NPORT*DW-1:0] m_pwdata,
  output logic [NPORT*SW-1:0] m_pstrb
);

  // Payload is broadcast; only select and enable are per port.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign m_psel[p]              = port_sel[p];
    assign m_penable[p]           = port_sel[p] & up_penable;
    assign m_pwrite[p]            = up_pwrite;
    assign m_paddr[p*AW +: AW]    = up_paddr;
    assign m_pprot[p*3 +: 3]      = up_pprot;
    assign m_pwdata[p*DW +: DW]   = up_pwdata;
    assign m_pstrb[p*SW +: SW]    = up_pstrb;
  end

endmodule

// File: rtl/apb_resp_mux.sv
module apb_resp_mux #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NPORT = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up_psel,
  input  logic [NPORT-1:0]    port_sel,
  input  logic [NPORT*DW-1:0] m_prdata,
  input  logic [NPORT-1:0]    m_pready,
  input  logic [NPORT-1:0]    m_pslverr,
  output logic [DW-1:0]       up_prdata,
  output logic                up_pready,
  output logic                up_pslverr
);

  logic [DW-1:0] or_data;
  logic          or_ready;
  logic          or_err;
  logic          any_hit;

  // AND-OR mux: idle ports contribute zero, so no X leaks through.
  always_comb begin
    or_data  = '0;
    or_ready = 1'b0;
    or_err   = 1'b0;
    for (int p = 0; p < int'(NPORT); p++) begin
      if (port_sel[p]) begin
        or_data  = or_data | m_prdata[p*DW +: DW];
        or_ready = or_ready | m_pready[p];
        or_err   = or_err | m_pslverr[p];
      end
    end
  end

  assign any_hit = |port_sel;

  always_comb begin
    if (!up_psel) begin
      up_prdata  = '0;
      up_pready  = 1'b0;
      up_pslverr = 1'b0;
    end else if (!any_hit) begin
      up_prdata  = '0;
      up_pready  = 1'b1;
      up_pslverr = 1'b1;
    end else begin
      up_prdata  = or_data;
      up_pready  = or_ready;
      up_pslverr = or_err;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_sel)); // R1
  AST_STALL_PASSES: assert property (@(posedge clk) disable iff (rst)
    (up_psel && ((port_sel & ~m_pready) != '0)) |-> !up_pready); // R5
  AST_READY_PASSES: assert property (@(posedge clk) disable iff (rst)
    (up_psel && ((port_sel & m_pready) != '0)) |-> up_pready); // R5

endmodule

// File: rtl/apb_fanout_split.sv
module apb_fanout_split #(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_TGT = 3,
  parameter apb_split_pkg::region_cfg_t MAP [NUM_TGT] = '{
    '{base: 32'h0000, stride_log2: 8'd8, rows: 16'd1, cols: 16'd1},
    '{base: 32'h1000, stride_log2: 8'd8, rows: 16'd1, cols: 16'd4},
    '{base: 32'h2000, stride_log2: 8'd6, rows: 16'd2, cols: 16'd3}
  },
  localparam int unsigned SW    = DW / 8,
  localparam int unsigned NPORT = port_ofs(NUM_TGT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_psel,
  input  logic                s_penable,
  input  logic                s_pwrite,
  input  logic [AW-1:0]       s_paddr,
  input  logic [2:0]          s_pprot,
  input  logic [DW-1:0]       s_pwdata,
  input  logic [SW-1:0]       s_pstrb,
  output logic [DW-1:0]       s_prdata,
  output logic                s_pready,
  output logic                s_pslverr,
  output logic [NPORT-1:0]    m_psel,
  output logic [NPORT-1:0]    m_penable,
  output logic [NPORT-1:0]    m_pwrite,
  output logic [NPORT*AW-1:0] m_paddr,
  output logic [NPORT*3-1:0]  m_pprot,
  output logic [NPORT*DW-1:0] m_pwdata,
  output logic [NPORT*SW-1:0] m_pstrb,
  input  logic [NPORT*DW-1:0] m_prdata,
  input  logic [NPORT-1:0]    m_pready,
  input  logic [NPORT-1:0]    m_pslverr
);

  // First downstream port number of region t (element counts summed).
  function automatic int unsigned port_ofs(input int unsigned t);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < t; i++) s += apb_split_pkg::region_count(MAP[i]);
    return s;
  endfunction

  logic [NPORT-1:0] port_sel;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_rgn
    localparam int unsigned OFS = port_ofs(t);
    localparam int unsigned CNT = apb_split_pkg::region_count(MAP[t]);
    logic [CNT-1:0] rsel;
    apb_region_decode #(.AW(AW), .CFG(MAP[t])) u_dec (
      .up_psel  (s_psel),
      .paddr    (s_paddr),
      .elem_sel (rsel)
    );
    assign port_sel[OFS +: CNT] = rsel;
  end

  apb_req_fanout #(.AW(AW), .DW(DW), .NPORT(NPORT)) u_fan (
    .up_penable (s_penable),
    .up_pwrite  (s_pwrite),
    .up_paddr   (s_paddr),
    .up_pprot   (s_pprot),
    .up_pwdata  (s_pwdata),
    .up_pstrb   (s_pstrb),
    .port_sel   (port_sel),
    .m_psel     (m_psel),
    .m_penable  (m_penable),
    .m_pwrite   (m_pwrite),
    .m_paddr    (m_paddr),
    .m_pprot    (m_pprot),
    .m_pwdata   (m_pwdata),
    .m_pstrb    (m_pstrb)
  );

  apb_resp_mux #(.DW(DW), .NPORT(NPORT)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .up_psel    (s_psel),
    .port_sel   (port_sel),
    .m_prdata   (m_prdata),
    .m_pready   (m_pready),
    .m_pslverr  (m_pslverr),
    .up_prdata  (s_prdata),
    .up_pready  (s_pready),
    .up_pslverr (s_pslverr)
  );

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    !s_psel |-> (m_psel == '0 && m_penable == '0)); // R2
  AST_EN_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    (m_penable & ~m_psel) == '0); // R4
  AST_MISS_ERROR: assert property (@(posedge clk) disable iff (rst)
    (s_psel && m_psel == '0) |-> (s_pready && s_pslverr && s_prdata == '0)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !s_psel |-> (!s_pready && !s_pslverr && s_prdata == '0)); // R8

endmodule

// File: tb/apb_fanout_split_test.sv
module apb_fanout_split_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int NP = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_psel = 0, s_penable = 0, s_pwrite = 0;
  logic [AW-1:0] s_paddr = '0;
  logic [2:0]    s_pprot = '0;
  logic [DW-1:0] s_pwdata = '0;
  logic [SW-1:0] s_pstrb = '0;
  logic [DW-1:0] s_prdata;
  logic s_pready, s_pslverr;
  logic [NP-1:0] m_psel, m_penable, m_pwrite;
  logic [NP*AW-1:0] m_paddr;
  logic [NP*3-1:0]  m_pprot;
  logic [NP*DW-1:0] m_pwdata;
  logic [NP*SW-1:0] m_pstrb;
  logic [NP*DW-1:0] m_prdata;
  logic [NP-1:0] m_pready, m_pslverr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_fanout_split uut (
    .clk(clk), .rst(rst), .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
    .s_paddr(s_paddr), .s_pprot(s_pprot), .s_pwdata(s_pwdata), .s_pstrb(s_pstrb),
    .s_prdata(s_prdata), .s_pready(s_pready), .s_pslverr(s_pslverr),
    .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite), .m_paddr(m_paddr),
    .m_pprot(m_pprot), .m_pwdata(m_pwdata), .m_pstrb(m_pstrb),
    .m_prdata(m_prdata), .m_pready(m_pready), .m_pslverr(m_pslverr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Base address of each downstream port under the default map (R6).
  function automatic logic [AW-1:0] port_addr(input int p);
    if (p == 0) return 16'h0000;
    if (p <= 4) return 16'h1000 + 16'(p - 1) * 16'h100;
    return 16'h2000 + 16'(p - 5) * 16'h40;
  endfunction

  function automatic logic [DW-1:0] rd_word(input int p);
    return 32'hA500_0000 | (32'(p) * 32'h111);
  endfunction

  task automatic go_idle();
    @(negedge clk);
    s_psel = 0; s_penable = 0; s_pwrite = 0;
    #1;
  endtask

  task automatic t_idle_state(input string tag);
    s_paddr = 16'h1100;
    #1;
    chk(m_psel == '0, "R2", {tag, " psel idle"}, 64'(m_psel), 0);
    chk(m_penable == '0, "R2", {tag, " penable idle"}, 64'(m_penable), 0);
    chk(s_pready == 0 && s_pslverr == 0, "R8", {tag, " ready/err idle"},
        {s_pready, s_pslverr}, 0);
    chk(s_prdata == '0, "R8", {tag, " rdata idle"}, 64'(s_prdata), 0);
  endtask

  // Full write + read transfer to one mapped address, expecting port p.
  task automatic t_transfer(input logic [AW-1:0] addr, input int p);
    logic [DW-1:0] wd;
    logic [NP-1:0] onehot;
    onehot = NP'(1) << p;
    wd = 32'h1357_9BDF ^ (32'(addr) * 32'h1021);
    @(negedge clk);
    s_psel = 1; s_penable = 0; s_pwrite = 1; s_paddr = addr;
    s_pwdata = wd; s_pstrb = '1; s_pprot = 3'(p);
    #1;  // same half cycle, no clock edge since the drive (R9)
    chk(m_psel == onehot, "R1", $sformatf("one-hot select addr %h", addr), 64'(m_psel), 64'(onehot));
    chk(m_penable == '0, "R4", "setup phase enable", 64'(m_penable), 0);
    chk(m_paddr[p*AW +: AW] == addr, "R3", "address forwarded", 64'(m_paddr[p*AW +: AW]), 64'(addr));
    chk(m_pwdata[p*DW +: DW] == wd, "R3", "wdata forwarded", 64'(m_pwdata[p*DW +: DW]), 64'(wd));
    chk(m_pstrb[p*SW +: SW] == '1, "R3", "full strobe forwarded", 64'(m_pstrb[p*SW +: SW]), 64'hF);
    chk(m_pprot[p*3 +: 3] == 3'(p), "R3", "prot forwarded", 64'(m_pprot[p*3 +: 3]), 64'(3'(p)));
    chk(m_pwrite[p] == 1'b1, "R3", "write bit forwarded", 64'(m_pwrite[p]), 1);
    @(negedge clk);
    s_penable = 1;
    #1;
    chk(m_penable == onehot, "R4", "access phase enable", 64'(m_penable), 64'(onehot));
    chk(s_pready == 1'b1, "R5", "write ready", 64'(s_pready), 1);
    chk(s_pslverr == 1'(p % 2), "R5", "write error steered", 64'(s_pslverr), 64'(p % 2));
    go_idle();
    @(negedge clk);
    s_psel = 1; s_penable = 0; s_pwrite = 0; s_paddr = addr;
    #1;
    chk(m_pwrite[p] == 1'b0, "R3", "read direction forwarded", 64'(m_pwrite[p]), 0);
    @(negedge clk);
    s_penable = 1;
    #1;
    chk(s_prdata == rd_word(p), "R5", $sformatf("read data port %0d", p), 64'(s_prdata), 64'(rd_word(p)));
    chk(m_psel == onehot, "R6", "element index from stride", 64'(m_psel), 64'(onehot));
    go_idle();
  endtask

  task automatic t_sweep();
    for (int p = 0; p < NP; p++) t_transfer(port_addr(p) + 16'(4 * p), p);
    // element [1][0] of the 2x3 array is index 3 -> port 8 (R6)
    t_transfer(16'h20C0, 8);
  endtask

  task automatic t_unmapped(input logic [AW-1:0] addr, input string req);
    @(negedge clk);
    s_psel = 1; s_penable = 0; s_pwrite = 0; s_paddr = addr;
    #1;
    chk(m_psel == '0, req, $sformatf("no select for %h", addr), 64'(m_psel), 0);
    @(negedge clk);
    s_penable = 1;
    #1;
    chk(m_penable == '0, "R7", "no enable on miss", 64'(m_penable), 0);
    chk(s_pready == 1 && s_pslverr == 1, "R7", "miss ready/error", {s_pready, s_pslverr}, 2'b11);
    chk(s_prdata == '0, "R7", "miss rdata zero", 64'(s_prdata), 0);
    go_idle();
  endtask

  task automatic t_boundary();
    t_transfer(16'h00FF, 0);   // R10 last byte of single target
    t_unmapped(16'h0100, "R10");
    t_transfer(16'h13FF, 4);   // R10 last element of 1x4 array
    t_unmapped(16'h1400, "R10");
    t_transfer(16'h217F, 10);  // R10 last element of 2x3 array
    t_unmapped(16'h2180, "R10");
  endtask

  task automatic t_wait_state();
    m_pready[3] = 1'b0;
    @(negedge clk);
    s_psel = 1; s_penable = 1; s_pwrite = 0; s_paddr = port_addr(3);
    #1;
    chk(s_pready == 1'b0, "R5", "stalled port holds ready low", 64'(s_pready), 0);
    m_pready[3] = 1'b1;
    #1;
    chk(s_pready == 1'b1, "R5", "ready follows port same cycle", 64'(s_pready), 1);
    chk(s_prdata == rd_word(3), "R5", "rdata after wait", 64'(s_prdata), 64'(rd_word(3)));
    go_idle();
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_prdata[p*DW +: DW] = rd_word(p);
      m_pslverr[p] = 1'(p % 2);
    end
    m_pready = '1;
    t_idle_state("reset");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_idle_state("after reset");
    t_sweep();
    t_boundary();
    t_unmapped(16'h0800, "R7");
    t_wait_state();
    t_idle_state("final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule